// File: doc/BRIEF.md
# Accumulator Fetch/Execute Core

This block is a compact multi-cycle processor core built around an 8-bit accumulator, a four-bit flag nibble and a 16-bit program counter. It reads opcodes and immediate operands, one byte at a time, from a synchronous memory with a single-cycle read latency. It executes four instructions: a no-operation, an accumulator increment that updates the flags, an absolute jump whose 16-bit target follows the opcode, and a register-indirect jump through the H:L register pair.

Any opcode outside that set stops the core for good and raises a fault output that only a reset clears. A halt input lets the surrounding system park the core on an instruction boundary. A one-cycle retire pulse, together with the exposed program counter, accumulator, flag and H:L values, lets a checker compare the architectural state after each instruction.

Top module: `tc_core`

## Requirements
- R1: While reset is asserted on a clock edge, the program counter loads `RESET_PC` (default 0x0000). The accumulator, flags and H:L load zero, and `fault` and `instrDone` are low.
- R2: `flagsOut` holds Zero at bit 7, Subtract at bit 6, Half-carry at bit 5 and Carry at bit 4. Bits 3..0 always read zero.
- R3: Opcode 0x00 changes nothing except the program counter, which advances by one. It retires two cycles after its fetch edge.
- R4: Opcode 0x3C sets the accumulator to (A+1) mod 256. Zero is set exactly when the result is 0x00. Subtract is cleared. Half-carry is set exactly when the result's low nibble is 0x0. Carry keeps its value. The instruction retires three cycles after its fetch edge.
- R5: Opcode 0xC3 reads the byte at PC+1 as the low half and the byte at PC+2 as the high half of the target, then loads the program counter with {high, low}. It retires four cycles after its fetch edge.
- R6: Opcode 0xE9 loads the program counter with {H, L}, which is 0x0000 after reset. It retires three cycles after its fetch edge.
- R7: `instrDone` is high for exactly one cycle per retired instruction. In that cycle the exposed architectural state already reflects the instruction.
- R8: Any other opcode raises `fault` in the cycle after decode. From then until reset, `fault` stays high, no memory read is issued, no instruction retires and the program counter does not move.
- R9: `halt` is sampled only at the start of an instruction. While it is high there, no read is issued and the state is frozen. An instruction already under way completes normally.
- R10: Each opcode fetch presents `memAddr` equal to the current program counter with `memRdEn` high. The byte appears on `memRdata` in the following cycle, and the program counter steps by one on that fetch edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| halt | input | 1 | Freeze request, honoured between instructions |
| memRdEn | output | 1 | Read strobe to the synchronous memory |
| memAddr | output | 16 | Byte address of the read |
| memRdata | input | 8 | Read data, valid one cycle after the strobe |
| instrDone | output | 1 | One-cycle pulse per retired instruction |
| fault | output | 1 | Sticky invalid-opcode indication |
| pcOut | output | 16 | Program counter |
| accOut | output | 8 | Accumulator |
| flagsOut | output | 8 | Flag register (upper nibble used) |
| hlOut | output | 16 | H:L register pair |

## Verification
A wrong control state shows up at the ports within one instruction. A mis-sequenced fetch presents an address other than the program counter on the next fetch, and a wrong latency moves the `instrDone` pulse by at least one cycle from the cycle a per-opcode count predicts. A corrupted datapath register shows up at the next retire pulse as a mismatch in the program counter, the accumulator or the flags. The increment loop drives the accumulator through the 0x0F and 0xFF boundaries so that the half-carry and zero rules are both exercised. A swapped operand order is caught by a jump to 0x1234, which lands somewhere else if the two bytes are reversed.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2 * DATA_W;
  localparam int NIB_W  = DATA_W / 2;

  // flag bit positions inside the flag byte
  localparam int FLAG_Z = 7;
  localparam int FLAG_N = 6;
  localparam int FLAG_H = 5;
  localparam int FLAG_C = 4;

  localparam logic [DATA_W-1:0] OP_NOP   = 8'h00;
  localparam logic [DATA_W-1:0] OP_INCA  = 8'h3C;
  localparam logic [DATA_W-1:0] OP_JPIMM = 8'hC3;
  localparam logic [DATA_W-1:0] OP_JPHL  = 8'hE9;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_READLO,
    ST_READHI,
    ST_EXEC,
    ST_FAULT
  } coreState_e;

  typedef struct packed {
    logic pcInc;
    logic latchLo;
    logic jumpImm;
    logic jumpHl;
    logic incAcc;
  } ctrlStrobe_t;
endpackage

// File: rtl/tc_ctrl.sv
module tc_ctrl
  import tc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              halt,
  input  logic [DATA_W-1:0] opByte,
  output ctrlStrobe_t       strobe,
  output logic              memRdEn,
  output logic              instrDone,
  output logic              fault
);
  coreState_e state, stateNext;
  logic execInc, execIncNext;
  logic retire;
  logic doneQ;

  always_comb begin
    stateNext   = state;
    execIncNext = execInc;
    strobe      = '0;
    memRdEn     = 1'b0;
    retire      = 1'b0;
    case (state)
      ST_FETCH: begin
        if (!halt) begin
          memRdEn      = 1'b1;
          strobe.pcInc = 1'b1;
          stateNext    = ST_DECODE;
        end
      end
      ST_DECODE: begin
        case (opByte)
          OP_NOP: begin
            retire    = 1'b1;
            stateNext = ST_FETCH;
          end
          OP_INCA: begin
            execIncNext = 1'b1;
            stateNext   = ST_EXEC;
          end
          OP_JPHL: begin
            execIncNext = 1'b0;
            stateNext   = ST_EXEC;
          end
          OP_JPIMM: begin
            memRdEn      = 1'b1;
            strobe.pcInc = 1'b1;
            stateNext    = ST_READLO;
          end
          default: stateNext = ST_FAULT;
        endcase
      end
      ST_READLO: begin
        strobe.latchLo = 1'b1;
        strobe.pcInc   = 1'b1;
        memRdEn        = 1'b1;
        stateNext      = ST_READHI;
      end
      ST_READHI: begin
        strobe.jumpImm = 1'b1;
        retire         = 1'b1;
        stateNext      = ST_FETCH;
      end
      ST_EXEC: begin
        strobe.incAcc = execInc;
        strobe.jumpHl = !execInc;
        retire        = 1'b1;
        stateNext     = ST_FETCH;
      end
      ST_FAULT: stateNext = ST_FAULT;
      default:  stateNext = ST_FAULT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_FETCH;
      execInc <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      state   <= stateNext;
      execInc <= execIncNext;
      doneQ   <= retire;
    end
  end

  assign instrDone = doneQ;
  assign fault     = (state == ST_FAULT);

  // R8
  fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault);

  // R8
  fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    fault |-> (!memRdEn && !instrDone && strobe == '0));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    instrDone |=> !instrDone);

  // R9
  halt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH && halt) |=> (state == ST_FETCH && !instrDone));
endmodule

// File: rtl/tc_dpath.sv
module tc_dpath
  import tc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] flagsOut,
  output logic [ADDR_W-1:0] hlOut
);
  logic [ADDR_W-1:0] pcReg;
  logic [DATA_W-1:0] accReg;
  logic [DATA_W-1:0] hReg, lReg;
  logic [DATA_W-1:0] loByte;
  logic              flagZ, flagN, flagH, flagC;
  logic [DATA_W-1:0] incResult;

  assign incResult = accReg + DATA_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pcReg  <= RESET_PC;
      accReg <= '0;
      hReg   <= '0;
      lReg   <= '0;
      loByte <= '0;
      flagZ  <= 1'b0;
      flagN  <= 1'b0;
      flagH  <= 1'b0;
      flagC  <= 1'b0;
    end else begin
      if (strobe.pcInc)   pcReg  <= pcReg + ADDR_W'(1);
      if (strobe.latchLo) loByte <= memRdata;
      if (strobe.jumpImm) pcReg  <= {memRdata, loByte};
      if (strobe.jumpHl)  pcReg  <= {hReg, lReg};
      if (strobe.incAcc) begin
        accReg <= incResult;
        flagZ  <= (incResult == '0);
        flagN  <= 1'b0;
        flagH  <= (incResult[NIB_W-1:0] == '0);
      end
    end
  end

  always_comb begin
    flagsOut         = '0;
    flagsOut[FLAG_Z] = flagZ;
    flagsOut[FLAG_N] = flagN;
    flagsOut[FLAG_H] = flagH;
    flagsOut[FLAG_C] = flagC;
  end

  assign memAddr = pcReg;
  assign pcOut   = pcReg;
  assign accOut  = accReg;
  assign hlOut   = {hReg, lReg};

  // R10
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.pcInc |=> (pcOut == $past(pcOut) + ADDR_W'(1)));

  // R4
  inc_flags_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.incAcc |=> ((flagsOut[FLAG_Z] == (accOut == '0)) && !flagsOut[FLAG_N]
                       && (flagsOut[FLAG_H] == (accOut[NIB_W-1:0] == '0))
                       && (flagsOut[FLAG_C] == $past(flagsOut[FLAG_C]))));

  // R5
  jump_high_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.jumpImm |=> (pcOut[ADDR_W-1:DATA_W] == $past(memRdata)));
endmodule

// File: rtl/tc_core.sv
module tc_core
  import tc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdata,
  output logic              instrDone,
  output logic              fault,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] flagsOut,
  output logic [ADDR_W-1:0] hlOut
);
  ctrlStrobe_t strobe;

  tc_ctrl i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .halt      (halt),
    .opByte    (memRdata),
    .strobe    (strobe),
    .memRdEn   (memRdEn),
    .instrDone (instrDone),
    .fault     (fault)
  );

  tc_dpath #(.RESET_PC(RESET_PC)) i_dpath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .pcOut    (pcOut),
    .accOut   (accOut),
    .flagsOut (flagsOut),
    .hlOut    (hlOut)
  );

  // R2
  flag_low_chk: assert property (@(posedge clk) disable iff (rst)
    instrDone |-> (flagsOut[3:0] == 4'h0));
endmodule

// File: tb/test_tc_core.sv
module test_tc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        halt = 1'b0;
  logic        memRdEn;
  logic [15:0] memAddr;
  logic [7:0]  memRdata = 8'h00;
  logic        instrDone, fault;
  logic [15:0] pcOut, hlOut;
  logic [7:0]  accOut, flagsOut;

  tc_core i_tc_core (
    .clk(clk), .rst(rst), .halt(halt), .memRdEn(memRdEn), .memAddr(memAddr),
    .memRdata(memRdata), .instrDone(instrDone), .fault(fault), .pcOut(pcOut),
    .accOut(accOut), .flagsOut(flagsOut), .hlOut(hlOut)
  );

  always #5 clk = ~clk;

  logic [7:0] mem [256];
  always @(posedge clk) if (memRdEn) memRdata <= mem[memAddr[7:0]];

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [15:0] mPc, mHl;
  logic [7:0]  mAcc, mFlags;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rst  = 1'b1;
    halt = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(pcOut === 16'h0000, "R1 reset pc", pcOut, 0);
    chk(accOut === 8'h00 && flagsOut === 8'h00, "R1 reset acc/flags", {accOut, flagsOut}, 0);
    chk(hlOut === 16'h0000, "R1 reset hl", hlOut, 0);
    chk(fault === 1'b0 && instrDone === 1'b0, "R1 reset fault/done", {fault, instrDone}, 0);
    rst = 1'b0;
    mPc = 16'h0000; mHl = 16'h0000; mAcc = 8'h00; mFlags = 8'h00;
  endtask

  task automatic idleCycles(input int n, input string tag, input bit expFault);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      chk(memRdEn === 1'b0 && instrDone === 1'b0 && pcOut === mPc && fault === expFault,
          tag, {memRdEn, instrDone, fault, pcOut}, {2'b00, expFault, mPc});
    end
  endtask

  task automatic stepInstr(input bit raiseHalt);
    logic [7:0]  op, nAcc, nFlags;
    logic [15:0] nPc;
    int          lat;
    bit          bad;
    string       tag;
    bad = 0; nAcc = mAcc; nFlags = mFlags;
    op = mem[mPc[7:0]];
    case (op)
      8'h00: begin lat = 2; nPc = mPc + 16'd1; tag = "R3 nop"; end
      8'h3C: begin
        lat = 3; nPc = mPc + 16'd1; tag = "R4 inc";
        nAcc = mAcc + 8'd1;
        nFlags = {nAcc == 8'h00, 1'b0, nAcc[3:0] == 4'h0, mFlags[4], 4'b0000};
      end
      8'hC3: begin lat = 4; nPc = {mem[8'(mPc + 2)], mem[8'(mPc + 1)]}; tag = "R5 jp imm"; end
      8'hE9: begin lat = 3; nPc = mHl; tag = "R6 jp hl"; end
      default: begin lat = 2; nPc = mPc + 16'd1; bad = 1; tag = "R8 bad op"; end
    endcase
    #1;
    chk(memRdEn === 1'b1 && memAddr === mPc, "R10 fetch address", {memRdEn, memAddr}, {1'b1, mPc});
    for (int i = 1; i <= lat; i++) begin
      @(posedge clk); @(negedge clk);
      if (raiseHalt && i == 1) halt = 1'b1;
      if (i < lat) chk(instrDone === 1'b0, "R7 no early retire", instrDone, 0);
    end
    if (bad) begin
      chk(fault === 1'b1 && instrDone === 1'b0, "R8 fault raised", {fault, instrDone}, 2'b10);
      mPc = nPc;
    end else begin
      chk(instrDone === 1'b1, {"R7 retire pulse ", tag}, instrDone, 1);
      chk(pcOut === nPc, {tag, " pc"}, pcOut, nPc);
      chk(accOut === nAcc, {tag, " acc"}, accOut, nAcc);
      chk(flagsOut === nFlags, {tag, " flags"}, flagsOut, nFlags);
      chk(flagsOut[3:0] === 4'h0, "R2 low nibble zero", flagsOut, nFlags);
      mPc = nPc; mAcc = nAcc; mFlags = nFlags;
    end
  endtask

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 8'h00;
    // loop: nop, inc, jp 0x0005, (0x05) jp hl -> 0x0000
    mem[0] = 8'h00; mem[1] = 8'h3C; mem[2] = 8'hC3; mem[3] = 8'h05; mem[4] = 8'h00;
    mem[5] = 8'hE9;
    doReset();
    for (int k = 0; k < 1040; k++) begin
      stepInstr(k == 9);
      if (k == 9) begin
        idleCycles(6, "R9 halted between instructions", 1'b0);
        halt = 1'b0;
      end
    end
    chk(accOut === 8'h04, "R4 accumulator wrapped", accOut, 8'h04);

    // operand order and invalid opcode
    for (int a = 0; a < 256; a++) mem[a] = 8'h00;
    mem[0] = 8'hC3; mem[1] = 8'h34; mem[2] = 8'h12;
    mem[8'h34] = 8'h3C; mem[8'h35] = 8'h00; mem[8'h36] = 8'h76;
    doReset();
    stepInstr(1'b0);
    chk(pcOut === 16'h1234, "R5 low byte first", pcOut, 16'h1234);
    stepInstr(1'b0);
    stepInstr(1'b0);
    stepInstr(1'b0);
    idleCycles(8, "R8 fault sticky", 1'b1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule